// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This unit sits beside the command decoder of a serial EEPROM. It keeps the write enable latch and the nonvolatile protection settings: a hardware-lock enable bit and a two-bit block protection level. For every array byte or status update that the decoder asks for, it decides whether the request is allowed. The decision uses the latch, the protection level, the lock enable bit, the active-low write-protect pin and the state of the self-timed write cycle. It also builds the status byte that the decoder shifts out on a status read.

The decoder sends one-cycle strobes: latch set, latch clear, status update with its new field values, and array byte with its address. It also sends a one-cycle `cs_rise` pulse when chip select is released. Requests that pass are staged. On `cs_rise` a staged write is committed and a one-cycle `cycle_start` goes out to the external write timer. That timer drives `wcycle_busy` for the length of the programming cycle. The unit treats the falling edge of that flag as the end of the cycle it started.

Top module: `nvm_guard_unit`

## Requirements
- R1: After reset the write enable latch is 0. The lock enable bit and the protection level take the parameter values `WPEN_INIT` and `BP_INIT`. The status byte reads `{WPEN_INIT,3'b000,BP_INIT,1'b0,1'b0}`.
- R2: A latch-set strobe sets the latch and a latch-clear strobe clears it, whatever the level of `wp_n`. The latch is visible as status bit 1.
- R3: Status bit 7 is the lock enable, bits 3:2 are the protection level, bit 1 is the latch and bit 0 is the busy flag. When idle, bits 6:4 and bit 0 read 0. The whole byte reads 8'hFF while `wcycle_busy` is high, and also from the cycle after a cycle start until that cycle ends.
- R4: `byte_ok` is high only when an array byte strobe arrives, the latch is 1, the unit is not busy and the address lies outside the protected region. For `ADDR_W`=10 the protected region is: level 0, none; level 1, addresses 0x300 and above; level 2, 0x200 and above; level 3, every address.
- R5: The hardware lock is active when the lock enable bit is 1 and `wp_n` is 0. While the lock is active, status updates are refused, so the lock enable bit cannot be cleared. When the lock enable bit is 0, `wp_n` has no effect on status updates.
- R6: A status update is refused while the latch is 0. An accepted update loads `sr_new_wpen` and `sr_new_bp` at the next `cs_rise`.
- R7: If the hardware lock becomes active while an accepted status update is staged and not yet committed, the update is dropped. The status is unchanged and no cycle starts. Once committed, later changes on `wp_n` do not alter it.
- R8: `cycle_start` is a one-cycle pulse in the cycle after a `cs_rise` that found a staged write. A `cs_rise` with nothing staged, such as after a page whose bytes all fell in a protected region, starts no cycle.
- R9: When `wcycle_busy` falls after a cycle that this unit started, the write enable latch clears.
- R10: While busy, latch strobes, status updates and array bytes are ignored. `sr_ok` and `byte_ok` stay 0 and the latch keeps its value across the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Strobe: set write enable latch |
| cmd_wrdi | input | 1 | Strobe: clear write enable latch |
| cmd_wrsr | input | 1 | Strobe: request status update |
| sr_new_wpen | input | 1 | New lock enable value for a status update |
| sr_new_bp | input | 2 | New protection level for a status update |
| cmd_wr_byte | input | 1 | Strobe: request array byte write |
| wr_addr | input | ADDR_W | Array byte address |
| cs_rise | input | 1 | Pulse on chip select release |
| wp_n | input | 1 | Write-protect pin, active low |
| wcycle_busy | input | 1 | High while the self-timed write runs |
| status_byte | output | 8 | Status byte for a status read |
| sr_ok | output | 1 | Status update accepted (same cycle as strobe) |
| byte_ok | output | 1 | Array byte accepted (same cycle as strobe) |
| cycle_start | output | 1 | One-cycle pulse to start the write timer |

## Verification
The assertions assume that the decoder's strobes are one cycle long and that at most one strobe is high per cycle. They also assume that `wcycle_busy` rises only after a `cycle_start` (or as a deliberate external busy period) and later falls again. The stimulus keeps to this. Each command is driven for a single cycle on the falling clock edge. A small timer model in the bench raises `wcycle_busy` after it sees `cycle_start`, holds it for a few cycles and then drops it. The sweeps visit every address at every protection level and every combination of lock enable, pin level and latch state.

// File: rtl/nvm_guard_pkg.sv
`timescale 1ns/1ps
package nvm_guard_pkg;

    localparam int unsigned STAT_W   = 8;
    localparam int unsigned LEVEL_W  = 2;

    typedef enum logic [LEVEL_W-1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_level_e;

    typedef struct packed {
        logic               wel;       // write enable latch
        logic               wpen;      // nonvolatile lock enable
        logic [LEVEL_W-1:0] bp;        // nonvolatile protection level
        logic               sr_pend;   // status update staged
        logic               sr_wpen;   // staged lock enable
        logic [LEVEL_W-1:0] sr_bp;     // staged level
        logic               arr_pend;  // array bytes staged
        logic               cyc_pend;  // own cycle in flight
        logic               busy_q;    // busy flag, one cycle late
        logic               start;     // cycle start pulse
    } guard_state_t;

endpackage

// File: rtl/nvm_guard_region.sv
`timescale 1ns/1ps
module nvm_guard_region
    import nvm_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LEVEL_W-1:0] level,
    output logic               hit
);
    localparam int unsigned     SPAN  = 1 << ADDR_W;
    localparam int unsigned     CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] QTR_BASE  = CMP_W'((SPAN / 4) * 3);
    localparam logic [CMP_W-1:0] HALF_BASE = CMP_W'(SPAN / 2);

    logic [CMP_W-1:0] addr_x;

    always_comb begin
        addr_x = {1'b0, addr};
        unique case (prot_level_e'(level))
            LVL_NONE:    hit = 1'b0;
            LVL_QUARTER: hit = (addr_x >= QTR_BASE);
            LVL_HALF:    hit = (addr_x >= HALF_BASE);
            default:     hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvm_guard_policy.sv
`timescale 1ns/1ps
module nvm_guard_policy (
    input  logic wel,
    input  logic wpen,
    input  logic wp_n,
    input  logic busy,
    input  logic region_hit,
    input  logic sr_req,
    input  logic arr_req,
    output logic hw_lock,
    output logic sr_ok,
    output logic arr_ok
);
    always_comb begin
        hw_lock = wpen & ~wp_n;
        sr_ok   = sr_req  & wel & ~busy & ~hw_lock;
        arr_ok  = arr_req & wel & ~busy & ~region_hit;
    end
endmodule

// File: rtl/nvm_guard_status.sv
`timescale 1ns/1ps
module nvm_guard_status
    import nvm_guard_pkg::*;
(
    input  logic               busy,
    input  logic               wpen,
    input  logic [LEVEL_W-1:0] bp,
    input  logic               wel,
    output logic [STAT_W-1:0]  stat
);
    always_comb begin
        if (busy) stat = '1;
        else      stat = {wpen, 3'b000, bp, wel, 1'b0};
    end
endmodule

// File: rtl/nvm_guard_unit.sv
`timescale 1ns/1ps
module nvm_guard_unit
    import nvm_guard_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 10,
    parameter logic               WPEN_INIT = 1'b0,
    parameter logic [LEVEL_W-1:0] BP_INIT   = 2'b00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wren,
    input  logic               cmd_wrdi,
    input  logic               cmd_wrsr,
    input  logic               sr_new_wpen,
    input  logic [1:0]         sr_new_bp,
    input  logic               cmd_wr_byte,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               cs_rise,
    input  logic               wp_n,
    input  logic               wcycle_busy,
    output logic [7:0]         status_byte,
    output logic               sr_ok,
    output logic               byte_ok,
    output logic               cycle_start
);
    localparam guard_state_t RST_STATE = '{
        wel: 1'b0, wpen: WPEN_INIT, bp: BP_INIT,
        sr_pend: 1'b0, sr_wpen: 1'b0, sr_bp: '0,
        arr_pend: 1'b0, cyc_pend: 1'b0, busy_q: 1'b0, start: 1'b0
    };

    guard_state_t q, d;
    logic busy_eff;
    logic region_hit;
    logic hw_lock;
    logic cycle_done;

    assign busy_eff   = wcycle_busy | q.cyc_pend;
    assign cycle_done = q.cyc_pend & q.busy_q & ~wcycle_busy;

    nvm_guard_region #(.ADDR_W(ADDR_W)) u_region (
        .addr  (wr_addr),
        .level (q.bp),
        .hit   (region_hit)
    );

    nvm_guard_policy u_policy (
        .wel        (q.wel),
        .wpen       (q.wpen),
        .wp_n       (wp_n),
        .busy       (busy_eff),
        .region_hit (region_hit),
        .sr_req     (cmd_wrsr),
        .arr_req    (cmd_wr_byte),
        .hw_lock    (hw_lock),
        .sr_ok      (sr_ok),
        .arr_ok     (byte_ok)
    );

    nvm_guard_status u_status (
        .busy (busy_eff),
        .wpen (q.wpen),
        .bp   (q.bp),
        .wel  (q.wel),
        .stat (status_byte)
    );

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.busy_q = wcycle_busy;

        // end of own programming cycle
        if (cycle_done) begin
            d.cyc_pend = 1'b0;
            d.wel      = 1'b0;
        end

        // command intake, blocked while busy
        if (!busy_eff) begin
            if (cmd_wren)      d.wel = 1'b1;
            else if (cmd_wrdi) d.wel = 1'b0;
            if (sr_ok) begin
                d.sr_pend = 1'b1;
                d.sr_wpen = sr_new_wpen;
                d.sr_bp   = sr_new_bp;
            end
            if (byte_ok) d.arr_pend = 1'b1;
        end

        // lock asserted before commit drops a staged status update
        if (q.sr_pend && hw_lock) d.sr_pend = 1'b0;

        // commit at chip select release
        if (cs_rise) begin
            if (d.sr_pend) begin
                d.wpen  = d.sr_wpen;
                d.bp    = d.sr_bp;
                d.start = 1'b1;
            end else if (d.arr_pend) begin
                d.start = 1'b1;
            end
            if (d.start) d.cyc_pend = 1'b1;
            d.sr_pend  = 1'b0;
            d.arr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_STATE;
        else        q <= d;
    end

    assign cycle_start = q.start;
endmodule

// File: rtl/nvm_guard_chk.sv
`timescale 1ns/1ps
module nvm_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrsr,
    input logic       cmd_wr_byte,
    input logic       cs_rise,
    input logic       wp_n,
    input logic       wcycle_busy,
    input logic [7:0] status_byte,
    input logic       sr_ok,
    input logic       byte_ok,
    input logic       cycle_start
);
    AST_BUSY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wcycle_busy |-> status_byte == 8'hFF);                                   // R3
    AST_IDLE_PADDING: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte != 8'hFF |-> (status_byte[6:4] == 3'b000 && !status_byte[0])); // R3
    AST_START_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> status_byte == 8'hFF);                                   // R3
    AST_WEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && status_byte != 8'hFF) |=> (status_byte[1] || status_byte == 8'hFF)); // R2
    AST_BYTE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_byte && !status_byte[1]) |-> !byte_ok);                          // R4
    AST_BYTE_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_byte && status_byte[3:2] == 2'b11) |-> !byte_ok);                // R4
    AST_HW_LOCK_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && status_byte[7] && !wp_n) |-> !sr_ok);                       // R5
    AST_SR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !status_byte[1]) |-> !sr_ok);                               // R6
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);                                           // R8
    AST_START_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> $past(cs_rise));                                         // R8
    AST_BUSY_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_byte && status_byte == 8'hFF) |-> !byte_ok);                     // R10
endmodule

bind nvm_guard_unit nvm_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_wr_byte (cmd_wr_byte),
    .cs_rise     (cs_rise),
    .wp_n        (wp_n),
    .wcycle_busy (wcycle_busy),
    .status_byte (status_byte),
    .sr_ok       (sr_ok),
    .byte_ok     (byte_ok),
    .cycle_start (cycle_start)
);

// File: tb/sim_nvm_guard_unit.sv
`timescale 1ns/1ps
module sim_nvm_guard_unit;
    localparam int unsigned AW   = 10;
    localparam int unsigned SPAN = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, sr_new_wpen = 0;
    logic [1:0] sr_new_bp = 0;
    logic cmd_wr_byte = 0;
    logic [AW-1:0] wr_addr = '0;
    logic cs_rise = 0, wp_n = 1, wcycle_busy = 0;
    logic [7:0] status_byte;
    logic sr_ok, byte_ok, cycle_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nvm_guard_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .sr_new_wpen(sr_new_wpen), .sr_new_bp(sr_new_bp),
        .cmd_wr_byte(cmd_wr_byte), .wr_addr(wr_addr), .cs_rise(cs_rise),
        .wp_n(wp_n), .wcycle_busy(wcycle_busy), .status_byte(status_byte),
        .sr_ok(sr_ok), .byte_ok(byte_ok), .cycle_start(cycle_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] idle_stat(input logic wpen, input logic [1:0] bp, input logic wel);
        return {wpen, 3'b000, bp, wel, 1'b0};
    endfunction

    function automatic int unsigned lvl_base(input int lvl);
        case (lvl)
            0: return SPAN;
            1: return (SPAN / 4) * 3;
            2: return SPAN / 2;
            default: return 0;
        endcase
    endfunction

    task automatic set_wel(input logic v);
        @(negedge clk);
        if (v) cmd_wren = 1; else cmd_wrdi = 1;
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0;
    endtask

    task automatic sr_req(input logic wpen, input logic [1:0] bp, input logic exp_ok, input string tag);
        @(negedge clk);
        cmd_wrsr = 1; sr_new_wpen = wpen; sr_new_bp = bp;
        #1 check(tag, sr_ok, exp_ok);
        @(negedge clk);
        cmd_wrsr = 0;
    endtask

    // release chip select; model the write timer if a cycle starts
    task automatic release_cs(input logic exp_start, input bit wp_low_in_cycle);
        @(negedge clk);
        cs_rise = 1;
        @(negedge clk);
        cs_rise = 0;
        check("R8 cycle_start", cycle_start, exp_start);
        if (exp_start) begin
            check("R3 ff after start", status_byte, 8'hFF);
            wcycle_busy = 1;
            if (wp_low_in_cycle) wp_n = 0;
            repeat (4) @(negedge clk);
            check("R3 ff while busy", status_byte, 8'hFF);
            wcycle_busy = 0;
            @(negedge clk);
            check("R9 wel cleared after cycle", status_byte[1], 1'b0);
            check("R3 rdy idle", status_byte[0], 1'b0);
            wp_n = 1;
        end else begin
            @(negedge clk);
            check("R8 no start later", cycle_start, 1'b0);
        end
    endtask

    task automatic program_sr(input logic wpen, input logic [1:0] bp);
        set_wel(1);
        sr_req(wpen, bp, 1'b1, "R6 sr accepted");
        release_cs(1'b1, 1'b0);
        check("R6 sr loaded", status_byte, idle_stat(wpen, bp, 1'b0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset status", status_byte, 8'h00);
        check("R1 no start", cycle_start, 1'b0);

        // R2 latch set / clear, pin level irrelevant
        set_wel(1);
        check("R2 wren", status_byte, idle_stat(0, 2'b00, 1));
        wp_n = 0;
        set_wel(0);
        check("R2 wrdi with wp low", status_byte[1], 1'b0);
        set_wel(1);
        check("R2 wren with wp low", status_byte[1], 1'b1);
        set_wel(0);
        wp_n = 1;

        // R6 refused without latch
        sr_req(1'b0, 2'b01, 1'b0, "R6 sr without wel");
        release_cs(1'b0, 1'b0);
        check("R6 status untouched", status_byte, 8'h00);

        // R4 latch required for array bytes
        @(negedge clk);
        cmd_wr_byte = 1; wr_addr = 10'h010;
        #1 check("R4 byte without wel", byte_ok, 1'b0);
        @(negedge clk);
        cmd_wr_byte = 0;
        release_cs(1'b0, 1'b0);

        // R4 / R8 sweep of every address at every level
        for (int lvl = 0; lvl < 4; lvl++) begin
            program_sr(1'b0, 2'(lvl));
            set_wel(1);
            for (int a = 0; a < SPAN; a++) begin
                @(negedge clk);
                cmd_wr_byte = 1; wr_addr = AW'(a);
                #1 check("R4 region decode", byte_ok, (a < int'(lvl_base(lvl))) ? 1'b1 : 1'b0);
            end
            @(negedge clk);
            cmd_wr_byte = 0;
            release_cs(lvl != 3, 1'b0);
            if (lvl == 3) begin
                check("R8 dropped page keeps wel", status_byte[1], 1'b1);
                set_wel(0);
            end
        end
        program_sr(1'b0, 2'b00);

        // R5 matrix over lock enable, pin and latch
        for (int e = 0; e < 2; e++) begin
            program_sr(1'(e), 2'b00);
            for (int p = 0; p < 2; p++) begin
                for (int w = 0; w < 2; w++) begin
                    logic ok;
                    set_wel(1'(w));
                    wp_n = 1'(p);
                    ok = (w == 1) && !(e == 1 && p == 0);
                    sr_req(1'(e), 2'b00, ok, "R5 sr permission");
                    release_cs(ok, 1'b0);
                    wp_n = 1;
                    if (!ok && w == 1) set_wel(0);
                end
            end
        end
        // locked: clearing the lock enable bit is refused
        wp_n = 0;
        set_wel(1);
        sr_req(1'b0, 2'b00, 1'b0, "R5 clear wpen under lock");
        release_cs(1'b0, 1'b0);
        check("R5 wpen kept", status_byte[7], 1'b1);
        wp_n = 1;
        set_wel(0);

        // R7 lock during staging cancels; after commit it does not
        set_wel(1);
        sr_req(1'b1, 2'b01, 1'b1, "R7 staged");
        @(negedge clk); wp_n = 0;
        @(negedge clk); wp_n = 1;
        release_cs(1'b0, 1'b0);
        check("R7 cancelled status", status_byte, idle_stat(1, 2'b00, 1));
        sr_req(1'b1, 2'b01, 1'b1, "R7 restaged");
        release_cs(1'b1, 1'b1);
        check("R7 committed despite wp", status_byte, 8'h84);
        program_sr(1'b0, 2'b00);

        // R10 external busy blocks everything
        @(negedge clk);
        wcycle_busy = 1;
        @(negedge clk);
        check("R3 external busy ff", status_byte, 8'hFF);
        cmd_wren = 1;
        @(negedge clk);
        cmd_wren = 0;
        wcycle_busy = 0;
        repeat (2) @(negedge clk);
        check("R10 wren ignored", status_byte[1], 1'b0);
        set_wel(1);
        wcycle_busy = 1;
        @(negedge clk);
        cmd_wrdi = 1;
        @(negedge clk);
        cmd_wrdi = 0; cmd_wr_byte = 1; wr_addr = 10'h001;
        #1 check("R10 byte refused busy", byte_ok, 1'b0);
        @(negedge clk);
        cmd_wr_byte = 0; cmd_wrsr = 1;
        #1 check("R10 sr refused busy", sr_ok, 1'b0);
        @(negedge clk);
        cmd_wrsr = 0;
        wcycle_busy = 0;
        repeat (2) @(negedge clk);
        check("R10 wrdi ignored", status_byte, idle_stat(0, 2'b00, 1));
        release_cs(1'b0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule